// File: doc/BRIEF.md
# Sigma-Delta Calibration Step Sequencer

This block decides when a sigma-delta converter runs a calibration step, which kind of step it runs, and how long the step lasts. A calibration strobe must stay high for a minimum number of master-clock cycles and then drop. When it drops, one step starts. The step type comes from a two-bit select that is captured on the strobe's rising edge. A unipolar/bipolar range select is captured on the same edge.

While a step runs, the block holds the data-ready indication inactive. It marks which capture is in progress: zero scale or full scale. It also shows whether that capture takes its level from the input pin or from an internal level (ground or reference).

At the end of a step the block asks the output stage to force the next word. After an offset step the word is forced to all zeros; after a gain step it is forced to all ones. A two-step system calibration must run its offset step before its gain step. A gain request that breaks this order is refused and flagged. Step lengths are parameters; the defaults are the full cycle counts.

Top module: `adc_cal_sequencer`

## Requirements
- R1: After reset the following outputs are 0: `calBusy`, both capture enables, `capFromPin`, both force pulses, `seqErr` and `rangeBip`.
- R2: A strobe that is sampled high on fewer than MIN_HOLD (4) consecutive clock edges has no effect. No step starts, and a step that is already running continues for its full length.
- R3: A strobe sampled high on at least MIN_HOLD edges and then sampled low starts a step. `calBusy` is high from the cycle after that first low sample, for exactly the step's cycle count.
- R4: A strobe sampled high on MIN_HOLD consecutive edges stops any running step. `calBusy` is low from the cycle after the MIN_HOLD-th high sample. The new step then starts when the strobe falls.
- R5: `calSel` is captured on the strobe's rising edge, and later changes to it are ignored. The codes are: 2'b01 self, 2'b11 system offset (first of two steps), 2'b00 system gain (second step), 2'b10 single-step system offset.
- R6: A self step of SELF_CYC cycles works in two halves. `zeroCapEn` is high for the first floor(SELF_CYC/2) cycles. `fullCapEn` is high for the rest. `capFromPin` stays 0 throughout, because the levels are ground and reference. No force pulse follows the step.
- R7: A system offset step keeps `zeroCapEn` and `capFromPin` high for all OFS_CYC cycles. It ends with a one-cycle `forceZero` pulse, in the first cycle in which `calBusy` is low.
- R8: A system gain step keeps `fullCapEn` and `capFromPin` high for all GAIN_CYC cycles and ends with a one-cycle `forceOnes` pulse. A gain request is accepted only if the last step to finish was a system offset step and no other step has started since. Otherwise no step starts, and `seqErr` pulses for one cycle.
- R9: A single-step offset of ONE_CYC cycles works in two halves. First, zero scale is taken from the pin for floor(ONE_CYC/2) cycles (`capFromPin`=1). Then full scale is taken from the reference (`capFromPin`=0). The step ends with a `forceZero` pulse.
- R10: `rangeBip` shows the `bipolarSel` value captured on the strobe's rising edge of the running step. It is stable while `calBusy` is high.
- R11: The two capture enables are never both high, and neither is high while `calBusy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| calStrobe | input | 1 | Calibration strobe |
| calSel | input | 2 | Step type select, captured on the strobe's rising edge |
| bipolarSel | input | 1 | Range select (1 = bipolar), captured on the strobe's rising edge |
| zeroCapEn | output | 1 | Zero-scale capture active |
| fullCapEn | output | 1 | Full-scale capture active |
| capFromPin | output | 1 | Active capture uses the input pin level |
| calBusy | output | 1 | Step running; data-ready held inactive |
| forceZero | output | 1 | One-cycle request to force an all-zeros word |
| forceOnes | output | 1 | One-cycle request to force an all-ones word |
| seqErr | output | 1 | One-cycle pulse for a refused gain request |
| rangeBip | output | 1 | Range captured for the current step |

## Verification
A wrong step-length counter shows up as a `calBusy` window of the wrong length, visible the moment the step should end. A wrong phase split moves the point where the zero-scale capture hands over to the full-scale capture, counted in cycles. A stale captured select is exposed by the next step's length and by its force pulse, or by the lack of one. A corrupted offset-done flag appears one step later: a gain request is then wrongly refused, or wrongly accepted without a `seqErr` pulse. A hold counter off by one either starts a step after a three-cycle strobe or stops a running step one cycle late.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [1:0] {
    KIND_SYS_GAIN = 2'b00,
    KIND_SELF     = 2'b01,
    KIND_ONE_OFS  = 2'b10,
    KIND_SYS_OFS  = 2'b11
  } calKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic clear;
  } dpCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic     launch;
    logic     abort;
    logic     lastCycle;
    logic     secondHalf;
    calKind_e kind;
    calKind_e pendKind;
  } dpStat_t;

endpackage

// File: rtl/cal_seq_dp.sv
module cal_seq_dp
  import cal_seq_pkg::*;
#(
  parameter int MIN_HOLD = 4,
  parameter int SELF_CYC = 3145655,
  parameter int OFS_CYC  = 1052599,
  parameter int GAIN_CYC = 1068813,
  parameter int ONE_CYC  = 2117389
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       calStrobe,
  input  logic [1:0] calSel,
  input  logic       bipolarSel,
  input  dpCmd_t     cmd,
  output dpStat_t    stat,
  output logic       rangeBip
);

  localparam int MAX_A   = (SELF_CYC > OFS_CYC) ? SELF_CYC : OFS_CYC;
  localparam int MAX_B   = (GAIN_CYC > ONE_CYC) ? GAIN_CYC : ONE_CYC;
  localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int HOLD_W  = $clog2(MIN_HOLD + 1);

  logic              strobeQ;
  logic [HOLD_W-1:0] holdCnt;
  calKind_e          pendKind, actKind;
  logic              pendRange, actRange;
  logic [CNT_W-1:0]  remain;
  logic [CNT_W-1:0]  actLen, fullStart;

  function automatic logic [CNT_W-1:0] lenOf(calKind_e k);
    case (k)
      KIND_SELF:    return CNT_W'(SELF_CYC);
      KIND_SYS_OFS: return CNT_W'(OFS_CYC);
      KIND_ONE_OFS: return CNT_W'(ONE_CYC);
      default:      return CNT_W'(GAIN_CYC);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobeQ   <= 1'b0;
      holdCnt   <= '0;
      pendKind  <= KIND_SELF;
      pendRange <= 1'b0;
    end else begin
      strobeQ <= calStrobe;
      if (!calStrobe) holdCnt <= '0;
      else if (holdCnt != HOLD_W'(MIN_HOLD)) holdCnt <= holdCnt + 1'b1;
      if (calStrobe && !strobeQ) begin
        pendKind  <= calKind_e'(calSel);
        pendRange <= bipolarSel;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain   <= '0;
      actKind  <= KIND_SELF;
      actRange <= 1'b0;
    end else if (cmd.clear) begin
      remain <= '0;
    end else if (cmd.load) begin
      remain   <= lenOf(pendKind) - 1'b1;
      actKind  <= pendKind;
      actRange <= pendRange;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  always_comb begin
    actLen          = lenOf(actKind);
    fullStart       = actLen - (actLen >> 1);
    stat.launch     = !calStrobe && strobeQ && (holdCnt >= HOLD_W'(MIN_HOLD));
    stat.abort      = calStrobe && (holdCnt >= HOLD_W'(MIN_HOLD - 1));
    stat.lastCycle  = (remain == '0);
    stat.secondHalf = (remain < fullStart);
    stat.kind       = actKind;
    stat.pendKind   = pendKind;
  end

  assign rangeBip = actRange;

endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
  import cal_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output logic    zeroCapEn,
  output logic    fullCapEn,
  output logic    capFromPin,
  output logic    calBusy,
  output logic    forceZero,
  output logic    forceOnes,
  output logic    seqErr
);

  logic busyQ;
  logic offsetDone;
  logic gainBlocked;

  assign gainBlocked = (stat.pendKind == KIND_SYS_GAIN) && !offsetDone;
  assign cmd.clear   = stat.abort;
  assign cmd.load    = stat.launch && !gainBlocked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ      <= 1'b0;
      offsetDone <= 1'b0;
      forceZero  <= 1'b0;
      forceOnes  <= 1'b0;
      seqErr     <= 1'b0;
    end else begin
      forceZero <= 1'b0;
      forceOnes <= 1'b0;
      seqErr    <= 1'b0;
      if (stat.abort) begin
        busyQ <= 1'b0;
      end else if (cmd.load) begin
        busyQ      <= 1'b1;
        offsetDone <= 1'b0;
      end else if (stat.launch) begin
        seqErr <= 1'b1;
      end else if (busyQ && stat.lastCycle) begin
        busyQ      <= 1'b0;
        forceZero  <= (stat.kind == KIND_SYS_OFS) || (stat.kind == KIND_ONE_OFS);
        forceOnes  <= (stat.kind == KIND_SYS_GAIN);
        offsetDone <= (stat.kind == KIND_SYS_OFS);
      end
    end
  end

  always_comb begin
    zeroCapEn  = 1'b0;
    fullCapEn  = 1'b0;
    capFromPin = 1'b0;
    case (stat.kind)
      KIND_SELF: begin
        zeroCapEn = busyQ && !stat.secondHalf;
        fullCapEn = busyQ && stat.secondHalf;
      end
      KIND_SYS_OFS: begin
        zeroCapEn  = busyQ;
        capFromPin = busyQ;
      end
      KIND_SYS_GAIN: begin
        fullCapEn  = busyQ;
        capFromPin = busyQ;
      end
      default: begin
        zeroCapEn  = busyQ && !stat.secondHalf;
        fullCapEn  = busyQ && stat.secondHalf;
        capFromPin = busyQ && !stat.secondHalf;
      end
    endcase
  end

  assign calBusy = busyQ;

endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
  import cal_seq_pkg::*;
#(
  parameter int MIN_HOLD = 4,
  parameter int SELF_CYC = 3145655,
  parameter int OFS_CYC  = 1052599,
  parameter int GAIN_CYC = 1068813,
  parameter int ONE_CYC  = 2117389
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       calStrobe,
  input  logic [1:0] calSel,
  input  logic       bipolarSel,
  output logic       zeroCapEn,
  output logic       fullCapEn,
  output logic       capFromPin,
  output logic       calBusy,
  output logic       forceZero,
  output logic       forceOnes,
  output logic       seqErr,
  output logic       rangeBip
);

  dpCmd_t  cmd;
  dpStat_t stat;

  cal_seq_dp #(
    .MIN_HOLD(MIN_HOLD), .SELF_CYC(SELF_CYC), .OFS_CYC(OFS_CYC),
    .GAIN_CYC(GAIN_CYC), .ONE_CYC(ONE_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .calStrobe(calStrobe), .calSel(calSel),
    .bipolarSel(bipolarSel), .cmd(cmd), .stat(stat), .rangeBip(rangeBip)
  );

  cal_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stat(stat), .cmd(cmd),
    .zeroCapEn(zeroCapEn), .fullCapEn(fullCapEn), .capFromPin(capFromPin),
    .calBusy(calBusy), .forceZero(forceZero), .forceOnes(forceOnes),
    .seqErr(seqErr)
  );

endmodule

// File: rtl/adc_cal_sequencer_chk.sv
module adc_cal_sequencer_chk #(
  parameter int MIN_HOLD = 4
) (
  input logic clk,
  input logic rstN,
  input logic calStrobe,
  input logic zeroCapEn,
  input logic fullCapEn,
  input logic capFromPin,
  input logic calBusy,
  input logic forceZero,
  input logic forceOnes,
  input logic seqErr,
  input logic rangeBip
);

  int holdChk;

  always_ff @(posedge clk) begin
    if (!rstN) holdChk <= 0;
    else if (!calStrobe) holdChk <= 0;
    else if (holdChk < MIN_HOLD) holdChk <= holdChk + 1;
  end

  AST_CAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(zeroCapEn && fullCapEn)); // R11
  AST_CAP_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (zeroCapEn || fullCapEn) |-> calBusy); // R11
  AST_PIN_NEEDS_CAP: assert property (@(posedge clk) disable iff (!rstN)
    capFromPin |-> (zeroCapEn || fullCapEn)); // R7
  AST_START_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calBusy) |-> ($past(holdChk) >= MIN_HOLD) && !$past(calStrobe)); // R2
  AST_LONG_HOLD_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (calStrobe && holdChk >= MIN_HOLD - 1) |=> !calBusy); // R4
  AST_ZERO_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    forceZero |-> (!calBusy && $past(calBusy))); // R7
  AST_ONES_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    forceOnes |-> (!calBusy && $past(calBusy) && !forceZero)); // R8
  AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    seqErr |-> !calBusy); // R8
  AST_RANGE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (calBusy && $past(calBusy)) |-> $stable(rangeBip)); // R10

endmodule

bind adc_cal_sequencer adc_cal_sequencer_chk #(.MIN_HOLD(MIN_HOLD)) u_chk (.*);

// File: tb/adc_cal_sequencer_bench.sv
module adc_cal_sequencer_bench;

  localparam int SELF_L = 10;
  localparam int OFS_L  = 6;
  localparam int GAIN_L = 7;
  localparam int ONE_L  = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic calStrobe = 1'b0;
  logic [1:0] calSel = 2'b01;
  logic bipolarSel = 1'b0;
  logic zeroCapEn, fullCapEn, capFromPin, calBusy;
  logic forceZero, forceOnes, seqErr, rangeBip;

  always #5 clk = ~clk;

  adc_cal_sequencer #(
    .MIN_HOLD(4), .SELF_CYC(SELF_L), .OFS_CYC(OFS_L),
    .GAIN_CYC(GAIN_L), .ONE_CYC(ONE_L)
  ) u_adc_cal_sequencer (
    .clk(clk), .rstN(rstN), .calStrobe(calStrobe), .calSel(calSel),
    .bipolarSel(bipolarSel), .zeroCapEn(zeroCapEn), .fullCapEn(fullCapEn),
    .capFromPin(capFromPin), .calBusy(calBusy), .forceZero(forceZero),
    .forceOnes(forceOnes), .seqErr(seqErr), .rangeBip(rangeBip)
  );

  typedef struct packed {
    logic [1:0] sel;
    logic [7:0] len;
    logic [7:0] zeros;
    logic       zPin;
    logic       fPin;
    logic       fz;
    logic       fo;
    logic       err;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'b01, 8'd10, 8'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'b11, 8'd6,  8'd6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{2'b00, 8'd7,  8'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{2'b00, 8'd0,  8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{2'b10, 8'd9,  8'd4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{2'b11, 8'd6,  8'd6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{2'b01, 8'd10, 8'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'b00, 8'd0,  8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  int checks = 0;
  int fails = 0;
  int busyCnt, zeroCnt, fullCnt, pinBad, fzCnt, foCnt, errCnt, firstBusy, rangeBad;
  logic expZPin, expFPin, expRange;

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sync();
    @(posedge clk);
    #1;
  endtask

  // strobe high for 'hold' sampled edges, then low
  task automatic strobe(input logic [1:0] sel, input int hold, input logic rng);
    calStrobe = 1'b1;
    calSel = sel;
    bipolarSel = rng;
    repeat (hold) @(posedge clk);
    #1 calStrobe = 1'b0;
  endtask

  // waits for the launch edge, then samples n cycles at the falling edge
  task automatic monitor(input int n);
    busyCnt = 0; zeroCnt = 0; fullCnt = 0; pinBad = 0;
    fzCnt = 0; foCnt = 0; errCnt = 0; firstBusy = -1; rangeBad = 0;
    @(posedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (calBusy) begin
        busyCnt++;
        if (firstBusy < 0) firstBusy = i;
        if (rangeBip !== expRange) rangeBad++;
      end
      if (zeroCapEn) begin
        zeroCnt++;
        if (capFromPin !== expZPin) pinBad++;
      end
      if (fullCapEn) begin
        fullCnt++;
        if (capFromPin !== expFPin) pinBad++;
      end
      if (forceZero) fzCnt++;
      if (forceOnes) foCnt++;
      if (seqErr) errCnt++;
    end
  endtask

  function automatic string reqOf(input logic [1:0] sel);
    case (sel)
      2'b01:   return "R6";
      2'b11:   return "R7";
      2'b10:   return "R9";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R3 watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    expZPin = 1'b0; expFPin = 1'b0; expRange = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", calBusy, 0, "busy after reset");
    chk("R1", zeroCapEn | fullCapEn | capFromPin, 0, "capture after reset");
    chk("R1", forceZero | forceOnes | seqErr, 0, "pulses after reset");
    chk("R1", rangeBip, 0, "range after reset");

    // table walk: R3, R6, R7, R8, R9 and the offset-then-gain order
    for (int v = 0; v < 8; v++) begin
      vec_t t = VECS[v];
      string r = reqOf(t.sel);
      expZPin = t.zPin; expFPin = t.fPin; expRange = 1'b0;
      sync();
      strobe(t.sel, 4, 1'b0);
      monitor(30);
      chk("R3", busyCnt, int'(t.len), {r, " busy length"});
      if (!t.err) chk("R3", firstBusy, 0, {r, " start cycle"});
      chk(r, zeroCnt, int'(t.zeros), "zero-capture cycles");
      chk(r, fullCnt, int'(t.len) - int'(t.zeros), "full-capture cycles");
      chk(r, pinBad, 0, "capture source mismatches");
      chk(r, fzCnt, int'(t.fz), "forceZero pulses");
      chk(r, foCnt, int'(t.fo), "forceOnes pulses");
      chk("R8", errCnt, int'(t.err), {r, " seqErr pulses"});
    end

    // R2: short strobe while idle starts nothing
    sync();
    strobe(2'b01, 3, 1'b0);
    monitor(30);
    chk("R2", busyCnt, 0, "busy after short strobe while idle");

    // R2: short strobe during a running self step is ignored
    expZPin = 1'b0; expFPin = 1'b0;
    sync();
    strobe(2'b01, 4, 1'b0);
    fork
      monitor(30);
      begin
        repeat (3) @(posedge clk);
        #1 calStrobe = 1'b1; calSel = 2'b11;
        repeat (3) @(posedge clk);
        #1 calStrobe = 1'b0;
      end
    join
    chk("R2", busyCnt, SELF_L, "self length with short strobe inside");
    chk("R2", fzCnt, 0, "no force after self with short strobe inside");

    // R4: long strobe stops a running step, then launches the new one
    sync();
    strobe(2'b01, 4, 1'b0);
    @(posedge clk);
    repeat (3) @(negedge clk);
    #1 calStrobe = 1'b1; calSel = 2'b10;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4", calBusy, 1, "busy after three high samples");
    @(posedge clk);
    @(negedge clk);
    chk("R4", calBusy, 0, "busy after fourth high sample");
    repeat (2) @(posedge clk);
    #1 calStrobe = 1'b0;
    expZPin = 1'b1; expFPin = 1'b0;
    monitor(30);
    chk("R4", busyCnt, ONE_L, "new step length after stop");
    chk("R4", zeroCnt, ONE_L / 2, "new step zero cycles after stop");

    // R5: select change after the rising edge is ignored
    expZPin = 1'b1; expFPin = 1'b0;
    sync();
    calStrobe = 1'b1; calSel = 2'b11;
    @(posedge clk);
    #1 calSel = 2'b00;
    repeat (4) @(posedge clk);
    #1 calStrobe = 1'b0;
    monitor(30);
    chk("R5", busyCnt, OFS_L, "step length uses captured select");
    chk("R5", fzCnt, 1, "forceZero uses captured select");
    chk("R5", foCnt, 0, "no forceOnes from late select");

    // R10: range captured at the rising edge, stable during the step
    expZPin = 1'b0; expFPin = 1'b0; expRange = 1'b1;
    sync();
    calStrobe = 1'b1; calSel = 2'b01; bipolarSel = 1'b1;
    @(posedge clk);
    #1 bipolarSel = 1'b0;
    repeat (3) @(posedge clk);
    #1 calStrobe = 1'b0;
    monitor(30);
    chk("R10", busyCnt, SELF_L, "busy length in range test");
    chk("R10", rangeBad, 0, "range mismatches while busy");
    expRange = 1'b0;
    sync();
    strobe(2'b01, 4, 1'b0);
    monitor(30);
    chk("R10", rangeBad, 0, "unipolar range mismatches while busy");
    chk("R10", rangeBip, 0, "unipolar range after step");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule